// File: doc/BRIEF.md
# Two-Level Masked Interrupt Router

This block collects a parameterised number of level-sensitive interrupt sources and delivers them to up to four processor cores. Every source passes through three gates before it reaches a core. The first is a global enable that is shared by all cores. The second is a per-source routing field that selects which cores may see the source. The third is a mask held separately for each core. A core's interrupt line is raised while at least one source passes all three gates for that core.

Software reaches the block over a simple single-cycle register bus with two windows. The global window holds:
- the enable set and clear strobes,
- one routing register per source,
- a read-only control word that reports how many sources exist.

The per-core window holds the mask set and clear strobes and an acknowledge register. Each access carries a core number, and per-core window accesses act on that core's state. Enables and masks are changed by writing a source index to a set or clear address, so no read-modify-write of a bitmap is needed. The acknowledge register returns the lowest-numbered source that is currently deliverable to the requesting core. By convention, software treats the low-numbered sources as core-private lines and the higher ones as shared lines, but the hardware applies one delivery rule to all of them.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset every source is globally disabled, every per-core mask bit is set and every routing field is zero. As a result, all interrupt lines are low, every acknowledge read returns 1023 and routing registers read zero.
- R2: A read of global offset 0x000 returns the number of sources in bits [11:2], with all other bits zero.
- R3: Writing a source index in wdata[9:0] to global offset 0x030 enables that source, and writing it to offset 0x034 disables it. An index at or above the source count changes nothing.
- R4: Writing a source index in wdata[9:0] to per-core offset 0x048 masks that source for the core named on bus_cpu, and offset 0x04C unmasks it. The masks of other cores are not affected.
- R5: The routing register of source s sits at global offset 0x100 + 4*s. Bit n of that register lets the source reach core n (bits [NUM_CPU-1:0]). Other written bits are dropped and read back as zero.
- R6: A source reaches core n only when all of the following hold: its input is high, it is globally enabled, routing bit n is set, and core n's mask bit for it is clear.
- R7: A read of per-core offset 0x044 returns, in bits [9:0], the lowest-numbered source deliverable to that core. It returns 1023 when none is deliverable. Read data appears on bus_rdata in the cycle after the read is presented.
- R8: irq_out[n] is the OR of all sources deliverable to core n. It follows input and state changes in the same cycle, with no register in the path.
- R9: Sources are level-sensitive, so lowering a source input withdraws it at once and nothing is latched.
- R10: Reads of unmapped offsets return zero and writes to them change no state. bus_rdata is zero in any cycle that follows a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_level | input | NUM_SRC | Level-sensitive source inputs |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_win | input | 1 | 0 = global window, 1 = per-core window |
| bus_cpu | input | CPU_W | Core issuing the access |
| bus_addr | input | ADDR_W | Byte offset within the window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after the read |
| irq_out | output | NUM_CPU | Interrupt line per core |

## Verification
The assertions take several things for granted about the inputs:
- bus_cpu names an existing core whenever an access is made,
- bus_write is known whenever bus_valid is high,
- src_level is already synchronous to clk.

The stimulus respects these assumptions by changing every input only on the falling clock edge. It holds each access for exactly one cycle and uses core numbers 0 to 3 only. Source patterns are set before each check, so the combinational interrupt lines are sampled only after they have settled.

// File: rtl/irq_ctrl_pkg.sv
// Package: shared constants and command encoding for the two-level interrupt router.
// Assumes a fixed 10-bit source index field in all index-bearing registers.
package irq_ctrl_pkg;

    localparam int IDX_W = 10;
    localparam logic [IDX_W-1:0] ACK_NONE = '1;

    localparam int OFS_CTRL     = 'h000;
    localparam int OFS_EN_SET   = 'h030;
    localparam int OFS_EN_CLR   = 'h034;
    localparam int OFS_ROUTE    = 'h100;
    localparam int OFS_ACK      = 'h044;
    localparam int OFS_MASK_SET = 'h048;
    localparam int OFS_MASK_CLR = 'h04C;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_SET  = 2'd1,
        CMD_CLR  = 2'd2
    } idx_cmd_e;

endpackage

// File: rtl/irq_enable_bank.sv
// Global enable bits and per-source core routing fields.
// Assumes at most one enable command and one routing write per cycle.
module irq_enable_bank
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 4,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  idx_cmd_e                          en_cmd,
    input  logic [IDX_W-1:0]                  en_idx,
    input  logic                              route_we,
    input  logic [SRC_W-1:0]                  route_sel,
    input  logic [NUM_CPU-1:0]                route_wdata,
    output logic [NUM_SRC-1:0]                src_en,
    output logic [NUM_SRC-1:0][NUM_CPU-1:0]   src_route
);

    // Update enable bits from index commands and routing fields from writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_en    <= '0;
            src_route <= '0;
        end else begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (en_idx == IDX_W'(s)) begin
                    if (en_cmd == CMD_SET)      src_en[s] <= 1'b1;
                    else if (en_cmd == CMD_CLR) src_en[s] <= 1'b0;
                end
                if (route_we && route_sel == SRC_W'(s)) begin
                    src_route[s] <= route_wdata;
                end
            end
        end
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
        p_set_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (en_cmd == CMD_SET && en_idx == IDX_W'(s)) |=> src_en[s]);
        p_clr_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (en_cmd == CMD_CLR && en_idx == IDX_W'(s)) |=> !src_en[s]);
    end

    p_en_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_cmd == CMD_NONE) |=> $stable(src_en));
    p_route_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !route_we |=> $stable(src_route));

endmodule

// File: rtl/irq_mask_bank.sv
// Per-core mask bits, set or cleared by index for the core named with the command.
// Assumes mask_cpu is below NUM_CPU whenever a command is issued.
module irq_mask_bank
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 4,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  idx_cmd_e                          mask_cmd,
    input  logic [IDX_W-1:0]                  mask_idx,
    input  logic [CPU_W-1:0]                  mask_cpu,
    output logic [NUM_CPU-1:0][NUM_SRC-1:0]   cpu_mask
);

    // Apply a set or clear command to one bit of the selected core's mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_mask <= '1;
        end else if (mask_cmd != CMD_NONE) begin
            for (int c = 0; c < NUM_CPU; c++) begin
                for (int s = 0; s < NUM_SRC; s++) begin
                    if (mask_cpu == CPU_W'(c) && mask_idx == IDX_W'(s)) begin
                        cpu_mask[c][s] <= (mask_cmd == CMD_SET);
                    end
                end
            end
        end
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
        p_other_cpu_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_cmd != CMD_NONE && mask_cpu != CPU_W'(c)) |=> $stable(cpu_mask[c]));
    end

    p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_cmd == CMD_NONE) |=> $stable(cpu_mask));

endmodule

// File: rtl/irq_lowest_pick.sv
// Finds the lowest-numbered asserted request; returns ACK_NONE when none.
// Assumes NUM_SRC is below 1023 so no valid index equals ACK_NONE.
module irq_lowest_pick
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   req,
    output logic [IDX_W-1:0]     pick_idx
);

    // Scan from the top so the lowest asserted index wins last.
    always_comb begin
        pick_idx = ACK_NONE;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) pick_idx = IDX_W'(i);
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
        p_pick_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (pick_idx == IDX_W'(i)) |-> req[i]);
        p_pick_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
            req[i] |-> (pick_idx <= IDX_W'(i)));
    end

endmodule

// File: rtl/irq_route_ctrl.sv
// Top: register decode, three-gate delivery per core, acknowledge readout.
// Assumes single-cycle bus accesses and sources synchronous to clk.
module irq_route_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_level,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic                 bus_win,
    input  logic [CPU_W-1:0]     bus_cpu,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_CPU-1:0]   irq_out
);

    localparam int ROUTE_END = OFS_ROUTE + 4 * NUM_SRC;
    localparam logic [DATA_W-1:0] CTRL_VAL = DATA_W'(NUM_SRC) << 2;

    logic                              g_wr, p_wr, rd_req;
    logic                              route_hit;
    logic [ADDR_W-1:0]                 route_off;
    logic [SRC_W-1:0]                  route_sel;
    idx_cmd_e                          en_cmd, mask_cmd;
    logic [NUM_SRC-1:0]                src_en;
    logic [NUM_SRC-1:0][NUM_CPU-1:0]   src_route;
    logic [NUM_CPU-1:0][NUM_SRC-1:0]   cpu_mask;
    logic [NUM_CPU-1:0][NUM_SRC-1:0]   route_col;
    logic [NUM_CPU-1:0][NUM_SRC-1:0]   deliver;
    logic [NUM_CPU-1:0][IDX_W-1:0]     ack_idx;
    logic [NUM_CPU-1:0]                rd_route;
    logic [IDX_W-1:0]                  rd_ack;
    logic [DATA_W-1:0]                 rd_next;
    logic                              wdata_unused;
    logic                              route_off_unused;

    assign g_wr   = bus_valid &  bus_write & ~bus_win;
    assign p_wr   = bus_valid &  bus_write &  bus_win;
    assign rd_req = bus_valid & ~bus_write;

    assign route_off = bus_addr - ADDR_W'(OFS_ROUTE);
    assign route_sel = route_off[SRC_W+1:2];
    assign route_hit = (bus_addr >= ADDR_W'(OFS_ROUTE)) && (bus_addr < ADDR_W'(ROUTE_END))
                       && (bus_addr[1:0] == 2'b00);
    assign wdata_unused     = ^bus_wdata[DATA_W-1:IDX_W];
    assign route_off_unused = ^{route_off[ADDR_W-1:SRC_W+2], route_off[1:0]};

    // Decode global-window writes into enable commands.
    always_comb begin
        en_cmd = CMD_NONE;
        if (g_wr && bus_addr == ADDR_W'(OFS_EN_SET))      en_cmd = CMD_SET;
        else if (g_wr && bus_addr == ADDR_W'(OFS_EN_CLR)) en_cmd = CMD_CLR;
    end

    // Decode per-core-window writes into mask commands.
    always_comb begin
        mask_cmd = CMD_NONE;
        if (p_wr && bus_addr == ADDR_W'(OFS_MASK_SET))      mask_cmd = CMD_SET;
        else if (p_wr && bus_addr == ADDR_W'(OFS_MASK_CLR)) mask_cmd = CMD_CLR;
    end

    irq_enable_bank #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_enable (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_cmd      (en_cmd),
        .en_idx      (bus_wdata[IDX_W-1:0]),
        .route_we    (g_wr & route_hit),
        .route_sel   (route_sel),
        .route_wdata (bus_wdata[NUM_CPU-1:0]),
        .src_en      (src_en),
        .src_route   (src_route)
    );

    irq_mask_bank #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .mask_cmd (mask_cmd),
        .mask_idx (bus_wdata[IDX_W-1:0]),
        .mask_cpu (bus_cpu),
        .cpu_mask (cpu_mask)
    );

    // Transpose routing fields into one bit-vector per core.
    always_comb begin
        for (int c = 0; c < NUM_CPU; c++) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                route_col[c][s] = src_route[s][c];
            end
        end
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        assign deliver[c] = src_level & src_en & route_col[c] & ~cpu_mask[c];
        assign irq_out[c] = |deliver[c];

        irq_lowest_pick #(.NUM_SRC(NUM_SRC)) u_pick (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (deliver[c]),
            .pick_idx (ack_idx[c])
        );

        p_line_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out[c] == (ack_idx[c] != ACK_NONE));
        p_line_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out[c] |-> |(src_level & src_en & ~cpu_mask[c]));
    end

    // Select the routing field and acknowledge value addressed by the read.
    always_comb begin
        rd_route = '0;
        rd_ack   = ACK_NONE;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (route_sel == SRC_W'(s)) rd_route = src_route[s];
        end
        for (int c = 0; c < NUM_CPU; c++) begin
            if (bus_cpu == CPU_W'(c)) rd_ack = ack_idx[c];
        end
    end

    // Form next read data; zero for writes, idle cycles and unmapped offsets.
    always_comb begin
        rd_next = '0;
        if (rd_req) begin
            if (!bus_win) begin
                if (bus_addr == ADDR_W'(OFS_CTRL)) rd_next = CTRL_VAL;
                else if (route_hit)                rd_next = DATA_W'(rd_route);
            end else if (bus_addr == ADDR_W'(OFS_ACK)) begin
                rd_next = DATA_W'(rd_ack);
            end
        end
    end

    // Register read data so it is presented one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_next;
    end

    p_rdata_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> (bus_rdata == '0));
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_out == '0));

endmodule

// File: tb/irq_route_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: vector table walked by one loop, then directed reset and idle-read tests.
module irq_route_ctrl_tb;

    localparam int NS = 64;
    localparam int NC = 4;

    typedef struct packed {
        logic [1:0]  op;
        logic        win;
        logic [1:0]  cpu;
        logic [11:0] addr;
        logic [31:0] data;
        logic [63:0] srcs;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam logic [1:0] OW = 2'd0;   // write
    localparam logic [1:0] OR = 2'd1;   // read, compare bus_rdata
    localparam logic [1:0] OI = 2'd2;   // compare irq_out
    localparam logic [63:0] S0   = 64'h1;
    localparam logic [63:0] S5   = 64'h20;
    localparam logic [63:0] S40  = 64'h0000_0100_0000_0000;
    localparam logic [63:0] S63  = 64'h8000_0000_0000_0000;
    localparam logic [63:0] SALL = 64'hFFFF_FFFF_FFFF_FFFF;

    localparam int NV = 44;
    localparam vec_t VEC [NV] = '{
        {OR, 1'b0, 2'd0, 12'h000, 32'h0,  64'h0,    32'h100, 4'd2},  // R2 source count
        {OR, 1'b1, 2'd0, 12'h044, 32'h0,  SALL,     32'h3FF, 4'd1},  // R1 nothing pending
        {OI, 1'b0, 2'd0, 12'h000, 32'h0,  SALL,     32'h0,   4'd1},  // R1 lines low
        {OW, 1'b0, 2'd0, 12'h030, 32'd40, 64'h0,    32'h0,   4'd3},
        {OI, 1'b0, 2'd0, 12'h000, 32'h0,  S40,      32'h0,   4'd6},  // R6 no route
        {OW, 1'b0, 2'd0, 12'h1A0, 32'h2,  64'h0,    32'h0,   4'd5},
        {OI, 1'b0, 2'd0, 12'h000, 32'h0,  S40,      32'h0,   4'd6},  // R6 masked
        {OW, 1'b1, 2'd1, 12'h04C, 32'd40, 64'h0,    32'h0,   4'd4},
        {OI, 1'b0, 2'd0, 12'h000, 32'h0,  S40,      32'h2,   4'd6},  // R6 all gates open
        {OR, 1'b1, 2'd1, 12'h044, 32'h0,  S40,      32'd40,  4'd7},  // R7
        {OR, 1'b0, 2'd0, 12'h1A0, 32'h0,  64'h0,    32'h2,   4'd5},  // R5
        {OW, 1'b0, 2'd0, 12'h1A0, 32'hFFFF_FFFF, 64'h0, 32'h0, 4'd5},
        {OR, 1'b0, 2'd0, 12'h1A0, 32'h0,  64'h0,    32'hF,   4'd5},  // R5 upper bits dropped
        {OI, 1'b0, 2'd0, 12'h000, 32'h0,  S40,      32'h2,   4'd4},  // R4 others still masked
        {OW, 1'b1, 2'd3, 12'h04C, 32'd40, 64'h0,    32'h0,   4'd4},
        {OI, 1'b0, 2'd0, 12'h000, 32'h0,  S40,      32'hA,   4'd8},  // R8
        {OW, 1'b0, 2'd0, 12'h030, 32'd5,  64'h0,    32'h0,   4'd3},
        {OW, 1'b0, 2'd0, 12'h114, 32'h8,  64'h0,    32'h0,   4'd5},
        {OW, 1'b1, 2'd3, 12'h04C, 32'd5,  64'h0,    32'h0,   4'd4},
        {OR, 1'b1, 2'd3, 12'h044, 32'h0,  S40 | S5, 32'd5,   4'd7},  // R7 lowest wins
        {OR, 1'b1, 2'd1, 12'h044, 32'h0,  S40 | S5, 32'd40,  4'd7},  // R7 per core
        {OI, 1'b0, 2'd0, 12'h000, 32'h0,  64'h0,    32'h0,   4'd9},  // R9 level drop
        {OW, 1'b1, 2'd3, 12'h048, 32'd5,  64'h0,    32'h0,   4'd4},
        {OR, 1'b1, 2'd3, 12'h044, 32'h0,  S40 | S5, 32'd40,  4'd4},  // R4 re-mask
        {OW, 1'b0, 2'd0, 12'h034, 32'd40, 64'h0,    32'h0,   4'd3},
        {OI, 1'b0, 2'd0, 12'h000, 32'h0,  S40,      32'h0,   4'd3},  // R3 disable
        {OW, 1'b0, 2'd0, 12'h100, 32'h1,  64'h0,    32'h0,   4'd5},
        {OW, 1'b1, 2'd0, 12'h04C, 32'd0,  64'h0,    32'h0,   4'd4},
        {OW, 1'b0, 2'd0, 12'h030, 32'd64, 64'h0,    32'h0,   4'd3},
        {OI, 1'b0, 2'd0, 12'h000, 32'h0,  S0,       32'h0,   4'd3},  // R3 out-of-range ignored
        {OW, 1'b0, 2'd0, 12'h030, 32'd0,  64'h0,    32'h0,   4'd3},
        {OI, 1'b0, 2'd0, 12'h000, 32'h0,  S0,       32'h1,   4'd6},  // R6
        {OR, 1'b1, 2'd0, 12'h044, 32'h0,  S0 | S5,  32'd0,   4'd7},  // R7 source 0
        {OW, 1'b0, 2'd0, 12'h00C, 32'hFFFF, 64'h0,  32'h0,   4'd10},
        {OR, 1'b0, 2'd0, 12'h00C, 32'h0,  64'h0,    32'h0,   4'd10}, // R10
        {OR, 1'b0, 2'd0, 12'h200, 32'h0,  64'h0,    32'h0,   4'd10}, // R10 past routing area
        {OR, 1'b1, 2'd0, 12'h048, 32'h0,  64'h0,    32'h0,   4'd10}, // R10 write-only offset
        {OI, 1'b0, 2'd0, 12'h000, 32'h0,  S0,       32'h1,   4'd10}, // R10 state intact
        {OR, 1'b0, 2'd0, 12'h100, 32'h0,  64'h0,    32'h1,   4'd5},  // R5
        {OW, 1'b0, 2'd0, 12'h030, 32'd63, 64'h0,    32'h0,   4'd3},
        {OW, 1'b0, 2'd0, 12'h1FC, 32'h4,  64'h0,    32'h0,   4'd5},
        {OW, 1'b1, 2'd2, 12'h04C, 32'd63, 64'h0,    32'h0,   4'd4},
        {OR, 1'b1, 2'd2, 12'h044, 32'h0,  S63,      32'd63,  4'd7},  // R7 top source
        {OI, 1'b0, 2'd0, 12'h000, 32'h0,  S63,      32'h4,   4'd6}   // R6
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_level = '0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic          bus_win = 1'b0;
    logic [1:0]    bus_cpu = '0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NC-1:0] irq_out;
    int            n_vec = 0;
    int            n_bad = 0;

    always #10 clk = ~clk;

    irq_route_ctrl #(.NUM_SRC(NS), .NUM_CPU(NC)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_level (src_level),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_win   (bus_win),
        .bus_cpu   (bus_cpu),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic check(input logic [3:0] rq, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        src_level = v.srcs;
        if (v.op == OI) begin
            #1;
            check(v.req, {28'b0, irq_out}, v.exp);
        end else begin
            bus_valid = 1'b1;
            bus_write = (v.op == OW);
            bus_win   = v.win;
            bus_cpu   = v.cpu;
            bus_addr  = v.addr;
            bus_wdata = v.data;
            @(negedge clk);
            bus_valid = 1'b0;
            bus_write = 1'b0;
            if (v.op == OR) check(v.req, bus_rdata, v.exp);
            else            n_vec++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R0 watchdog: actual 200000 cycles expected fewer");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) apply(VEC[i]);

        // R1: reset in mid-run restores disabled, masked, unrouted state.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        apply({OI, 1'b0, 2'd0, 12'h000, 32'h0, SALL, 32'h0, 4'd1});
        apply({OR, 1'b1, 2'd2, 12'h044, 32'h0, SALL, 32'h3FF, 4'd1});
        apply({OR, 1'b0, 2'd0, 12'h1FC, 32'h0, 64'h0, 32'h0, 4'd1});
        // R1: masks set again after reset, so enable+route alone delivers nothing.
        apply({OW, 1'b0, 2'd0, 12'h030, 32'd40, 64'h0, 32'h0, 4'd1});
        apply({OW, 1'b0, 2'd0, 12'h1A0, 32'hF, 64'h0, 32'h0, 4'd1});
        apply({OI, 1'b0, 2'd0, 12'h000, 32'h0, S40, 32'h0, 4'd1});

        // R10: read data returns to zero after an idle cycle.
        apply({OR, 1'b0, 2'd0, 12'h000, 32'h0, 64'h0, 32'h100, 4'd2});
        @(negedge clk);
        check(4'd10, bus_rdata, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule